// File: doc/BRIEF.md
# Pulse-Pause Carrier Frame Transmitter

This block sends one reader-to-tag frame by gating a carrier-enable output. Every data bit opens with a short carrier gap of fixed length, after which the carrier returns. The bit's value does not appear in the gap itself. It sets when the next gap begins, so a bit period is either long or short. Before its length is chosen, each data bit is whitened with a keystream bit from an external generator. The block pulses an advance strobe once per bit, so the generator steps in lockstep with the frame.

Timing is counted in ticks, qualified by a tick-enable input. With one tick every 32 system clocks, a long bit of 150 ticks lasts 100 µs. A start strobe loads the data word and the bit count. The bits then go out least significant first. One extra gap closes the frame, and the carrier then stays on. When that closing gap ends, the block emits a done pulse and a restart pulse for the response timer, so the tag's reply window can be measured from the end of the frame.

Top module: `ppm_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `carrier_en` is 1 and `busy` is 0.
- R2: Data bits go out least significant bit first. The number of bits sent equals `bit_count`.
- R3: Every bit begins with exactly 30 ticks of `carrier_en` = 0, and the carrier then returns to 1.
- R4: A bit whose encoded value is 1 lasts 150 ticks from the start of its gap to the start of the next gap. An encoded 0 lasts 90 ticks.
- R5: The encoded value is the data bit XOR `ks_bit`. For the first bit, `ks_bit` is sampled in the cycle the start is accepted. For each later bit, it is sampled on the tick that ends the previous bit.
- R6: `ks_adv` pulses exactly once per data bit, for one cycle, in the first clock of that bit's carrier-on part. It is never high while the carrier is off.
- R7: After the last bit, one closing gap of 30 ticks is sent, and `carrier_en` then stays 1.
- R8: In the clock after the closing gap's last tick, `done` and `timer_restart` are both 1 for exactly one cycle, with `busy` already 0.
- R9: A `start` that arrives while `busy` is 1 has no effect on the frame in progress.
- R10: A `bit_count` of 0 sends only the closing gap, with no `ks_adv` pulse.
- R11: Gap and bit lengths count only the cycles in which `tick_en` is 1, whatever the spacing of the ticks.
- R12: A `bit_count` above the data width (32) is treated as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle timing tick qualifier |
| start | input | 1 | Frame request, accepted only when idle |
| data_in | input | 32 | Frame bits, bit 0 sent first |
| bit_count | input | 6 | Number of bits to send |
| ks_bit | input | 1 | Current keystream bit from the external generator |
| ks_adv | output | 1 | Keystream advance strobe, one per bit |
| carrier_en | output | 1 | Carrier enable, 0 during gaps |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| timer_restart | output | 1 | One-cycle response-timer restart at frame end |

## Verification
The bench runs a behavioural reference model that expands each frame into a list of timed carrier segments and compares every output on every clock. Frames are sent under three tick patterns: a tick every cycle, a tick every third cycle, and irregular ticks. These separate lengths counted in ticks from lengths counted in clocks. Data values are alternating, all-ones and all-zeros. Combined with a keystream that changes from bit to bit, they show whether whitening is applied, whether it uses the right keystream step, and whether bits leave the word in the right order. Zero, single-bit, full-width and oversized counts, plus a start raised in the middle of a frame, exercise the edge cases of frame length and request handling.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

    localparam int unsigned PPM_DATA_W      = 32;
    localparam int unsigned PPM_GAP_TICKS   = 30;
    localparam int unsigned PPM_LONG_TICKS  = 150;
    localparam int unsigned PPM_SHORT_TICKS = 90;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BIT   = 2'd1,
        PH_CLOSE = 2'd2
    } ppm_phase_e;

    // Control strobes issued by the sequencer to the datapath pieces.
    typedef struct packed {
        logic load;
        logic step;
        logic clear;
    } ppm_ctl_t;

    // Timing events reported by the tick timer.
    typedef struct packed {
        logic in_gap;
        logic gap_end;
        logic period_end;
    } ppm_evt_t;

    function automatic int unsigned ppm_period(input logic enc,
                                               input int unsigned long_t,
                                               input int unsigned short_t);
        return enc ? long_t : short_t;
    endfunction

endpackage

// File: rtl/ppm_tick_timer.sv
module ppm_tick_timer
    import ppm_pkg::*;
#(
    parameter int unsigned GAP_TICKS   = PPM_GAP_TICKS,
    parameter int unsigned LONG_TICKS  = PPM_LONG_TICKS,
    parameter int unsigned SHORT_TICKS = PPM_SHORT_TICKS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_en,
    input  logic     active,
    input  logic     clear,
    input  logic     long_bit,
    output ppm_evt_t evt
);
    localparam int unsigned TICK_W = $clog2(LONG_TICKS + 1);
    localparam logic [TICK_W-1:0] GAP_LAST   = TICK_W'(GAP_TICKS - 1);
    localparam logic [TICK_W-1:0] LONG_LAST  = TICK_W'(LONG_TICKS - 1);
    localparam logic [TICK_W-1:0] SHORT_LAST = TICK_W'(SHORT_TICKS - 1);
    localparam logic [TICK_W-1:0] GAP_LEN    = TICK_W'(GAP_TICKS);

    logic [TICK_W-1:0] cnt_q;
    logic [TICK_W-1:0] period_last;
    logic              counting;

    assign counting    = active && tick_en;
    assign period_last = long_bit ? LONG_LAST : SHORT_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (counting) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        evt.in_gap     = cnt_q < GAP_LEN;
        evt.gap_end    = counting && (cnt_q == GAP_LAST);
        evt.period_end = counting && (cnt_q == period_last);
    end

    // R4: the tick count within a bit never runs past the long period.
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt_q <= LONG_LAST));

endmodule

// File: rtl/ppm_bit_shifter.sv
module ppm_bit_shifter
    import ppm_pkg::*;
#(
    parameter int unsigned DATA_W = PPM_DATA_W,
    parameter int unsigned CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  ppm_ctl_t          ctl,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CNT_W-1:0]  count_in,
    output logic              next_bit,
    output logic              last_bit,
    output logic              zero_len
);
    localparam logic [CNT_W-1:0] MAX_LEN = CNT_W'(DATA_W);

    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  left_q;
    logic [CNT_W-1:0]  eff_len;

    assign eff_len  = (count_in > MAX_LEN) ? MAX_LEN : count_in;
    assign zero_len = (eff_len == '0);
    assign next_bit = shreg_q[1];
    assign last_bit = (left_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            left_q  <= '0;
        end else if (ctl.load) begin
            shreg_q <= data_in;
            left_q  <= eff_len;
        end else if (ctl.step) begin
            shreg_q <= {1'b0, shreg_q[DATA_W-1:1]};
            left_q  <= left_q - 1'b1;
        end
    end

    // R2: a shift is only requested while bits remain.
    assert_step_valid_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.step |-> (left_q > CNT_W'(1)));

endmodule

// File: rtl/ppm_sequencer.sv
module ppm_sequencer
    import ppm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       first_bit,
    input  logic       next_bit,
    input  logic       last_bit,
    input  logic       zero_len,
    input  logic       ks_bit,
    input  ppm_evt_t   evt,
    output ppm_phase_e phase,
    output ppm_ctl_t   ctl,
    output logic       enc_bit,
    output logic       adv_pulse,
    output logic       end_pulse
);
    ppm_phase_e phase_q;
    logic       enc_q;
    logic       adv_q;
    logic       end_q;

    always_comb begin
        ctl = '0;
        unique case (phase_q)
            PH_IDLE: begin
                ctl.load  = start;
                ctl.clear = start;
            end
            PH_BIT: begin
                ctl.clear = evt.period_end;
                ctl.step  = evt.period_end && !last_bit;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            enc_q   <= 1'b0;
            adv_q   <= 1'b0;
            end_q   <= 1'b0;
        end else begin
            adv_q <= 1'b0;
            end_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        enc_q   <= first_bit ^ ks_bit;
                        phase_q <= zero_len ? PH_CLOSE : PH_BIT;
                    end
                end
                PH_BIT: begin
                    if (evt.gap_end) begin
                        adv_q <= 1'b1;
                    end
                    if (evt.period_end) begin
                        if (last_bit) begin
                            phase_q <= PH_CLOSE;
                        end else begin
                            enc_q <= next_bit ^ ks_bit;
                        end
                    end
                end
                PH_CLOSE: begin
                    if (evt.gap_end) begin
                        phase_q <= PH_IDLE;
                        end_q   <= 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase     = phase_q;
    assign enc_bit   = enc_q;
    assign adv_pulse = adv_q;
    assign end_pulse = end_q;

    // R8: the end-of-frame pulse never lasts more than one cycle.
    assert_end_single_R8: assert property (@(posedge clk) disable iff (rst)
        end_q |=> !end_q);

endmodule

// File: rtl/ppm_frame_tx.sv
module ppm_frame_tx
    import ppm_pkg::*;
#(
    parameter int unsigned DATA_W      = PPM_DATA_W,
    parameter int unsigned GAP_TICKS   = PPM_GAP_TICKS,
    parameter int unsigned LONG_TICKS  = PPM_LONG_TICKS,
    parameter int unsigned SHORT_TICKS = PPM_SHORT_TICKS,
    parameter int unsigned CNT_W       = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              start,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CNT_W-1:0]  bit_count,
    input  logic              ks_bit,
    output logic              ks_adv,
    output logic              carrier_en,
    output logic              busy,
    output logic              done,
    output logic              timer_restart
);
    ppm_phase_e phase;
    ppm_ctl_t   ctl;
    ppm_evt_t   evt;
    logic       enc_bit;
    logic       next_bit;
    logic       last_bit;
    logic       zero_len;
    logic       end_pulse;
    logic       active;

    assign active = (phase != PH_IDLE);

    ppm_tick_timer #(
        .GAP_TICKS  (GAP_TICKS),
        .LONG_TICKS (LONG_TICKS),
        .SHORT_TICKS(SHORT_TICKS)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .active  (active),
        .clear   (ctl.clear),
        .long_bit(enc_bit),
        .evt     (evt)
    );

    ppm_bit_shifter #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .data_in (data_in),
        .count_in(bit_count),
        .next_bit(next_bit),
        .last_bit(last_bit),
        .zero_len(zero_len)
    );

    ppm_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .first_bit(data_in[0]),
        .next_bit (next_bit),
        .last_bit (last_bit),
        .zero_len (zero_len),
        .ks_bit   (ks_bit),
        .evt      (evt),
        .phase    (phase),
        .ctl      (ctl),
        .enc_bit  (enc_bit),
        .adv_pulse(ks_adv),
        .end_pulse(end_pulse)
    );

    assign carrier_en    = !((phase == PH_BIT && evt.in_gap) || phase == PH_CLOSE);
    assign busy          = active;
    assign done          = end_pulse;
    assign timer_restart = end_pulse;

    // R1: with no frame in progress the carrier is on.
    assert_idle_carrier_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> carrier_en);

    // R6: the keystream advances only while the carrier is on during a frame.
    assert_adv_carrier_on_R6: assert property (@(posedge clk) disable iff (rst)
        ks_adv |-> (carrier_en && busy));

    // R8: frame end is reported with the block already idle and the timer restarted.
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && carrier_en && timer_restart));

    // R7: the closing gap hands over to a steady carrier.
    assert_close_to_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !carrier_en && !ks_adv) ##1 !busy |-> carrier_en && done);

endmodule

// File: tb/ppm_frame_tx_tb.sv
module ppm_frame_tx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_en = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic [CW-1:0] bit_count = '0;
    logic          ks_bit;
    logic          ks_adv, carrier_en, busy, done, timer_restart;

    ppm_frame_tx u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .start(start),
        .data_in(data_in), .bit_count(bit_count), .ks_bit(ks_bit),
        .ks_adv(ks_adv), .carrier_en(carrier_en), .busy(busy),
        .done(done), .timer_restart(timer_restart)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    int tick_mode = 0;
    int adv_seen = 0;
    logic [15:0] ks_state = 16'hACE1;
    logic [15:0] tick_rng = 16'h1D3F;

    assign ks_bit = ks_state[0];

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
    endfunction

    // Reference model: a frame is a list of carrier segments measured in ticks.
    int seg_len[$];
    int seg_kind[$];   // 0 gap of a bit, 1 carrier-on part of a bit, 2 closing gap
    bit m_busy = 0;
    int m_seg = 0;
    int m_used = 0;
    bit exp_done = 0;
    bit exp_adv = 0;

    task automatic build_frame(input logic [DW-1:0] d, input int cnt);
        logic [15:0] s;
        int n;
        bit enc;
        n = (cnt > DW) ? DW : cnt;
        s = ks_state;
        seg_len.delete();
        seg_kind.delete();
        for (int i = 0; i < n; i++) begin
            enc = d[i] ^ s[0];
            seg_len.push_back(30);
            seg_kind.push_back(0);
            seg_len.push_back(enc ? 120 : 60);
            seg_kind.push_back(1);
            s = lfsr_next(s);
        end
        seg_len.push_back(30);
        seg_kind.push_back(2);
    endtask

    always @(posedge clk) begin
        exp_done = 0;
        exp_adv  = 0;
        if (rst) begin
            m_busy = 0;
        end else if (!m_busy) begin
            if (start) begin
                build_frame(data_in, int'(bit_count));
                m_busy = 1;
                m_seg = 0;
                m_used = 0;
            end
        end else if (tick_en) begin
            m_used++;
            if (m_used == seg_len[m_seg]) begin
                m_seg++;
                m_used = 0;
                if (m_seg == seg_len.size()) begin
                    m_busy = 0;
                    exp_done = 1;
                end else if (seg_kind[m_seg] == 1) begin
                    exp_adv = 1;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cycles);
        end
    endtask

    // Compare away from the active edge, then update bench-driven inputs.
    always @(negedge clk) begin
        bit ec;
        string tag;
        cycles++;
        if (!rst) begin
            if (!m_busy) begin
                ec = 1; tag = "R1/R9";
            end else begin
                ec = (seg_kind[m_seg] == 1);
                tag = (seg_kind[m_seg] == 0) ? "R3/R11" :
                      (seg_kind[m_seg] == 1) ? "R2/R4/R5" : "R7/R10";
            end
            chk(tag, "carrier_en", int'(carrier_en), int'(ec));
            chk("R9", "busy", int'(busy), int'(m_busy));
            chk("R8", "done", int'(done), int'(exp_done));
            chk("R8", "timer_restart", int'(timer_restart), int'(exp_done));
            chk("R6", "ks_adv", int'(ks_adv), int'(exp_adv));
            if (ks_adv) begin
                ks_state = lfsr_next(ks_state);
                adv_seen++;
            end
        end
        tick_rng = lfsr_next(tick_rng);
        case (tick_mode)
            0: tick_en = 1'b1;
            1: tick_en = (cycles % 3 == 0);
            default: tick_en = tick_rng[0] ^ tick_rng[4];
        endcase
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic send(input logic [DW-1:0] d, input int cnt, input string req, input int exp_bits);
        @(negedge clk);
        data_in = d;
        bit_count = CW'(cnt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        adv_seen = 0;
        while (m_busy) @(negedge clk);
        @(negedge clk);
        chk(req, "ks_adv pulses per frame", adv_seen, exp_bits);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "carrier_en in reset", int'(carrier_en), 1);
        chk("R1", "busy in reset", int'(busy), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        tick_mode = 0;
        send(32'h0000_0055, 7, "R2/R6", 7);        // alternating data, R2 order
        send(32'h0, 0, "R10", 0);                  // R10 closing gap only
        send(32'h1, 1, "R4/R5", 1);                // single bit
        send(32'hFFFF_FFFF, 32, "R6", 32);         // full width, whitening visible
        send(32'h0, 12, "R5", 12);                 // zeros: encoded value is keystream

        tick_mode = 1;                             // R11 ticks every third cycle
        send(32'h0000_0B3C, 12, "R11", 12);
        send(32'h0, 0, "R10/R11", 0);

        tick_mode = 2;                             // R11 irregular ticks
        send(32'h1234_5678, 40, "R12", 32);        // R12 oversized count clamps

        // R9: a start raised mid-frame must not disturb the frame in progress
        tick_mode = 0;
        @(negedge clk);
        data_in = 32'h0000_0003;
        bit_count = CW'(5);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        adv_seen = 0;
        repeat (100) @(negedge clk);
        data_in = 32'hFFFF_FFFF;
        bit_count = CW'(20);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_busy) @(negedge clk);
        @(negedge clk);
        chk("R9", "ks_adv pulses with ignored start", adv_seen, 5);

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule